// File: doc/BRIEF.md
# Priority Interrupt Level Resolver

This block turns a set of pending interrupt requests into one priority level and decides whether the processor should take an interrupt trap. There are two request sources. A software request field holds one bit per software level. A vector of external lines holds one bit per hardware level. The block finds the highest level that is pending. It collects every pending bit into a summary mask and compares the level against the interrupt priority level the core is currently running at.

Evaluation is gated by an arm flag. Evaluating clears the flag, and the core re-arms it when it returns from privileged handler code. When an armed evaluation finds a level strictly above the current one, the block does three things: it stores the summary, it stores the winning level as the interrupt identifier, and it emits a one-cycle trap request. An asynchronous-trap request that is nonzero at evaluation time is not serviced. Instead it is reported on an error pulse.

Top module: `irq_level_resolver`

## Requirements
- R1: After reset, trapReq and astError are 0, intSummary and intId are 0, and the arm flag is set, so the first checkStrobe evaluates.
- R2: Software request bit k (k = 0 .. NUM_SW-1 of swReq) stands for level k+1 and sets summary bit SW_BASE+k. With the defaults this is bits 4..18 and levels 1..15.
- R3: External line bit k stands for level EXT_BASE+k and sets summary bit EXT_BASE+k. With the defaults this is levels and bits 20..30.
- R4: The chosen level is the highest pending level over both sources. The summary is the OR of every pending bit from both sources, with all other bits 0.
- R5: A trap is raised only if the chosen level is nonzero and strictly greater than curLevel. Otherwise trapReq stays 0 and intSummary and intId keep their values.
- R6: On a trap, intSummary, intId and trapReq all take their new values at the clock edge that samples the evaluation. trapReq is high for exactly that one cycle unless the next cycle also traps.
- R7: An evaluation happens only on a cycle with checkStrobe high while the arm flag is set, and it clears the flag whatever its outcome. A rearm pulse sets the flag for the next cycle, and rearm wins over the clear when both occur in the same cycle.
- R8: If astReq is nonzero during an evaluation, astError pulses for one cycle, no trap is raised, intSummary and intId are unchanged, and the arm flag is still cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| swReq | input | NUM_SW | Software request bits, bit k = level k+1 |
| extReq | input | NUM_EXT | External lines, bit k = level EXT_BASE+k |
| curLevel | input | LVL_W | Current interrupt priority level |
| astReq | input | AST_W | Asynchronous-trap request field (unsupported when nonzero) |
| checkStrobe | input | 1 | Request an evaluation |
| rearm | input | 1 | Return from privileged code; re-arms evaluation |
| trapReq | output | 1 | One-cycle interrupt trap request |
| astError | output | 1 | One-cycle unsupported-condition flag |
| intSummary | output | SUM_W | Latched summary of pending bits |
| intId | output | LVL_W | Latched winning level |

## Verification
The hardest cases to reach from the ports are the ones that hinge on the arm flag. The flag is never visible directly, so its state has to be read from whether a checkStrobe produces any response. The bench probes it by issuing a strobe with no rearm after a consumed evaluation, using requests that would otherwise trap. It also drives rearm and checkStrobe in the same cycle, then strobes again alone and expects a second trap in the very next cycle.

// File: rtl/irq_level_pkg.sv
package irq_level_pkg;

  // Strobes from the control path to the datapath.
  typedef struct packed {
    logic latchLevel;   // store summary and identifier this edge
  } ctrlStrobes_t;

endpackage

// File: rtl/irq_level_datapath.sv
module irq_level_datapath
  import irq_level_pkg::*;
#(
  parameter int SW_BASE  = 4,
  parameter int NUM_SW   = 15,
  parameter int EXT_BASE = 20,
  parameter int NUM_EXT  = 11,
  parameter int AST_W    = 4,
  localparam int SUM_W   = EXT_BASE + NUM_EXT,
  localparam int LVL_W   = $clog2(SUM_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SW-1:0]  swReq,
  input  logic [NUM_EXT-1:0] extReq,
  input  logic [LVL_W-1:0]   curLevel,
  input  logic [AST_W-1:0]   astReq,
  input  ctrlStrobes_t       strobes,
  output logic               candWins,
  output logic               astHit,
  output logic [SUM_W-1:0]   intSummary,
  output logic [LVL_W-1:0]   intId
);

  logic [SUM_W-1:0] pendMask;
  logic [LVL_W-1:0] swLevel;
  logic [LVL_W-1:0] extLevel;
  logic [LVL_W-1:0] bestLevel;

  // Place each request bit at its summary position.
  genvar g;
  generate
    for (g = 0; g < SUM_W; g++) begin : g_mask
      if (g >= SW_BASE && g < SW_BASE + NUM_SW) begin : g_sw
        assign pendMask[g] = swReq[g - SW_BASE];
      end else if (g >= EXT_BASE) begin : g_ext
        assign pendMask[g] = extReq[g - EXT_BASE];
      end else begin : g_none
        assign pendMask[g] = 1'b0;
      end
    end
  endgenerate

  // Highest software level: a later (higher) bit overrides an earlier one.
  always_comb begin
    swLevel = '0;
    for (int k = 0; k < NUM_SW; k++) begin
      if (swReq[k]) swLevel = LVL_W'(k + 1);
    end
  end

  // Highest external level.
  always_comb begin
    extLevel = '0;
    for (int k = 0; k < NUM_EXT; k++) begin
      if (extReq[k]) extLevel = LVL_W'(EXT_BASE + k);
    end
  end

  // External levels sit above all software levels, so any external wins.
  assign bestLevel = (extLevel != '0) ? extLevel : swLevel;
  assign candWins  = (bestLevel != '0) && (bestLevel > curLevel);
  assign astHit    = (astReq != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intSummary <= '0;
      intId      <= '0;
    end else if (strobes.latchLevel) begin
      intSummary <= pendMask;
      intId      <= bestLevel;
    end
  end

  // R5: the latched registers move only on a latch strobe.
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.latchLevel |=> ($stable(intId) && $stable(intSummary)));

  // R4: a latch never stores level zero.
  assert_nonzero_latch_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.latchLevel |=> (intId != '0));

endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
  import irq_level_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         checkStrobe,
  input  logic         rearm,
  input  logic         candWins,
  input  logic         astHit,
  output ctrlStrobes_t strobes,
  output logic         trapReq,
  output logic         astError
);

  logic armQ;
  logic evalNow;
  logic takeTrap;

  assign evalNow  = checkStrobe && armQ;
  assign takeTrap = evalNow && candWins && !astHit;
  assign strobes.latchLevel = takeTrap;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armQ     <= 1'b1;
      trapReq  <= 1'b0;
      astError <= 1'b0;
    end else begin
      armQ     <= rearm || (armQ && !checkStrobe);
      trapReq  <= takeTrap;
      astError <= evalNow && astHit;
    end
  end

  // R7: a trap follows a cycle with the check strobe present.
  assert_trap_needs_check_R7: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> $past(checkStrobe));

  // R8: the error flag follows a nonzero asynchronous request.
  assert_ast_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    astError |-> $past(astHit));

endmodule

// File: rtl/irq_level_resolver.sv
module irq_level_resolver
  import irq_level_pkg::*;
#(
  parameter int SW_BASE  = 4,
  parameter int NUM_SW   = 15,
  parameter int EXT_BASE = 20,
  parameter int NUM_EXT  = 11,
  parameter int AST_W    = 4,
  localparam int SUM_W   = EXT_BASE + NUM_EXT,
  localparam int LVL_W   = $clog2(SUM_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SW-1:0]  swReq,
  input  logic [NUM_EXT-1:0] extReq,
  input  logic [LVL_W-1:0]   curLevel,
  input  logic [AST_W-1:0]   astReq,
  input  logic               checkStrobe,
  input  logic               rearm,
  output logic               trapReq,
  output logic               astError,
  output logic [SUM_W-1:0]   intSummary,
  output logic [LVL_W-1:0]   intId
);

  ctrlStrobes_t strobes;
  logic         candWins;
  logic         astHit;

  irq_level_datapath #(
    .SW_BASE(SW_BASE), .NUM_SW(NUM_SW), .EXT_BASE(EXT_BASE),
    .NUM_EXT(NUM_EXT), .AST_W(AST_W)
  ) dataPath (
    .clk(clk), .rstN(rstN), .swReq(swReq), .extReq(extReq),
    .curLevel(curLevel), .astReq(astReq), .strobes(strobes),
    .candWins(candWins), .astHit(astHit),
    .intSummary(intSummary), .intId(intId)
  );

  irq_level_ctrl ctrlPath (
    .clk(clk), .rstN(rstN), .checkStrobe(checkStrobe), .rearm(rearm),
    .candWins(candWins), .astHit(astHit), .strobes(strobes),
    .trapReq(trapReq), .astError(astError)
  );

  // R5: a trapped level is strictly above the level seen at evaluation.
  assert_id_above_R5: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> (intId > $past(curLevel)));

  // R8: error and trap never coincide.
  assert_ast_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    astError |-> !trapReq);

  // R3: an external winner has its own bit set in the summary.
  assert_ext_bit_R3: assert property (@(posedge clk) disable iff (!rstN)
    (trapReq && (int'(intId) >= EXT_BASE)) |-> intSummary[intId]);

endmodule

// File: tb/irq_level_resolver_test.sv
`timescale 1ns/1ps
module irq_level_resolver_test;

  localparam int SUM_W = 31;
  localparam int LVL_W = 5;
  localparam int NV = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [14:0] swReq = '0;
  logic [10:0] extReq = '0;
  logic [4:0]  curLevel = '0;
  logic [3:0]  astReq = '0;
  logic checkStrobe = 1'b0;
  logic rearm = 1'b0;
  logic trapReq, astError;
  logic [SUM_W-1:0] intSummary;
  logic [LVL_W-1:0] intId;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  irq_level_resolver uut (
    .clk(clk), .rstN(rstN), .swReq(swReq), .extReq(extReq),
    .curLevel(curLevel), .astReq(astReq), .checkStrobe(checkStrobe),
    .rearm(rearm), .trapReq(trapReq), .astError(astError),
    .intSummary(intSummary), .intId(intId)
  );

  // Vector table: software bits, external bits, current level, async field.
  localparam logic [14:0] V_SW  [NV] = '{15'h0001, 15'h4000, 15'h4000, 15'h0000, 15'h0000,
                                         15'h0101, 15'h0000, 15'h0022, 15'h0001, 15'h7fff};
  localparam logic [10:0] V_EXT [NV] = '{11'h000, 11'h000, 11'h000, 11'h000, 11'h001,
                                         11'h400, 11'h400, 11'h000, 11'h000, 11'h7ff};
  localparam logic [4:0]  V_CUR [NV] = '{5'd0, 5'd14, 5'd15, 5'd0, 5'd19,
                                         5'd29, 5'd30, 5'd3, 5'd0, 5'd0};
  localparam logic [3:0]  V_AST [NV] = '{4'h0, 4'h0, 4'h0, 4'h0, 4'h0,
                                         4'h0, 4'h0, 4'h0, 4'h2, 4'h0};

  // Expected model, built from R2..R4.
  function automatic logic [4:0] modelLevel(logic [14:0] s, logic [10:0] e);
    logic [4:0] l = '0;
    for (int k = 0; k < 15; k++) if (s[k]) l = 5'(k + 1);
    for (int k = 0; k < 11; k++) if (e[k]) l = 5'(20 + k);
    return l;
  endfunction

  function automatic logic [SUM_W-1:0] modelSum(logic [14:0] s, logic [10:0] e);
    return ({e, 20'b0}) | (SUM_W'(s) << 4);
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulseRearm();
    @(negedge clk); rearm = 1'b1;
    @(negedge clk); rearm = 1'b0;
  endtask

  // Drive one evaluation cycle; outputs are sampled at the next falling edge.
  task automatic evaluate(logic [14:0] s, logic [10:0] e, logic [4:0] c, logic [3:0] a,
                          logic alsoRearm);
    swReq = s; extReq = e; curLevel = c; astReq = a;
    checkStrobe = 1'b1; rearm = alsoRearm;
    @(negedge clk);
    checkStrobe = 1'b0; rearm = 1'b0;
  endtask

  logic [SUM_W-1:0] heldSum = '0;
  logic [4:0] heldId = '0;

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin : stim
    logic [4:0] lvl;
    logic expTrap;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset values
    check("R1 trapReq", trapReq, 0);
    check("R1 astError", astError, 0);
    check("R1 intSummary", intSummary, 0);
    check("R1 intId", intId, 0);
    // R1: armed out of reset, first strobe evaluates
    evaluate(15'h0004, 11'h0, 5'd0, 4'h0, 1'b0);
    check("R1 armed trap", trapReq, 1);
    check("R2 level of sw bit2", intId, 3);
    check("R2 summary of sw bit2", intSummary, 31'h40);
    heldSum = intSummary; heldId = intId;
    @(negedge clk);
    check("R6 pulse width", trapReq, 0);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      pulseRearm();
      evaluate(V_SW[v], V_EXT[v], V_CUR[v], V_AST[v], 1'b0);
      lvl = modelLevel(V_SW[v], V_EXT[v]);
      expTrap = (V_AST[v] == 0) && (lvl != 0) && (lvl > V_CUR[v]);
      if (expTrap) begin
        heldSum = modelSum(V_SW[v], V_EXT[v]);
        heldId = lvl;
      end
      check($sformatf("R5 trap vec%0d", v), trapReq, expTrap);
      check($sformatf("R8 astError vec%0d", v), astError, V_AST[v] != 0);
      check($sformatf("R4 summary vec%0d", v), intSummary, heldSum);
      check($sformatf("R3 id vec%0d", v), intId, heldId);
      @(negedge clk);
      check($sformatf("R6 trap drop vec%0d", v), trapReq, 0);
      check($sformatf("R8 err drop vec%0d", v), astError, 0);
    end

    // R7: no rearm after a consumed evaluation -> strobe ignored
    evaluate(15'h0000, 11'h200, 5'd0, 4'h0, 1'b0);
    check("R7 disarmed no trap", trapReq, 0);
    check("R7 disarmed id held", intId, heldId);
    check("R7 disarmed sum held", intSummary, heldSum);

    // R8: an async error also consumes the arm
    pulseRearm();
    evaluate(15'h0010, 11'h0, 5'd0, 4'h8, 1'b0);
    check("R8 error pulse", astError, 1);
    check("R8 no trap", trapReq, 0);
    check("R8 id held", intId, heldId);
    evaluate(15'h0010, 11'h0, 5'd0, 4'h0, 1'b0);
    check("R8 arm cleared", trapReq, 0);

    // R7: rearm together with strobe keeps the arm for the next strobe
    pulseRearm();
    swReq = 15'h0002; extReq = 11'h0; curLevel = 5'd0; astReq = 4'h0;
    checkStrobe = 1'b1; rearm = 1'b1;
    @(negedge clk);
    rearm = 1'b0; extReq = 11'h002;
    check("R7 same-cycle trap", trapReq, 1);
    check("R2 same-cycle id", intId, 2);
    @(negedge clk);
    checkStrobe = 1'b0;
    check("R7 rearm kept, second trap", trapReq, 1);
    check("R3 second id", intId, 21);
    check("R4 second summary", intSummary, 31'h00200020);
    @(negedge clk);
    check("R6 pulse ends", trapReq, 0);

    // R5: equal level with external source does not trap
    pulseRearm();
    evaluate(15'h0, 11'h004, 5'd22, 4'h0, 1'b0);
    check("R5 equal no trap", trapReq, 0);
    check("R5 equal id held", intId, 21);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule